// File: doc/BRIEF.md
# Gate-Merged Shared Data Bus

This block is the internal data bus of a small processor core. The core has no tri-state drivers inside it, so the bus is built from plain gates. Every source module has its own output word and its own active-high disable line.

In the default form, a disabled source presents all ones, because its word is ORed with its disable. Each bus bit is then the AND of that bit over all sources. Only an enabled source can pull a bit low, and an idle bus reads all ones. A parameter selects the dual form instead. There a disabled source presents zeros, because its word is ANDed with its enable. The bus is then the OR over all sources, and an idle bus reads all zeros.

A single release input disables every source at once. This lets microcode park the bus without touching any write strobe. Two side outputs report the bus state. One flags a cycle in which more than one source drives. The other flags a bus that nobody drives. The contention flag also has a registered copy on a clock with synchronous reset.

Top module: `gbus_top`

## Requirements
- R1: In the default form, with every source disabled and release low, `bus_out` is all ones.
- R2: With exactly one source enabled (its `src_dis` bit 0, release low), `bus_out` equals that source's word exactly. Source k occupies `src_data[k*WIDTH +: WIDTH]`.
- R3: In the default form, with several sources enabled, `bus_out` is the bitwise AND of the enabled sources' words. Disabled sources have no effect on it.
- R4: While `bus_release` is 1, every source counts as disabled whatever `src_dis` holds. `bus_out` shows the idle value, `idle` is 1 and `contention` is 0.
- R5: `contention` is 1 exactly when two or more sources are enabled and release is low.
- R6: `idle` is 1 exactly when no source is enabled, either because all disables are high or because release is high.
- R7: In the dual form (`FORM = FORM_OR_ZERO`), the idle value is all zeros, and with several sources enabled `bus_out` is the bitwise OR of the enabled words.
- R8: `contention_q` is 0 after a clock edge with `rst` high. After any other edge it equals the `contention` value seen just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered contention flag |
| rst | input | 1 | Synchronous active-high reset of `contention_q` |
| src_data | input | N_SRC*WIDTH | Packed source words, source k at bits k*WIDTH upward |
| src_dis | input | N_SRC | Active-high disable, one bit per source |
| bus_release | input | 1 | Forces all sources disabled |
| bus_out | output | WIDTH | Merged bus word |
| contention | output | 1 | More than one source enabled (combinational) |
| contention_q | output | 1 | Registered copy of `contention` |
| idle | output | 1 | No source enabled |

## Verification
A release request and a multi-source contention pattern can arrive in the same cycle. The bench provokes this by holding several disables low, or all of them, while raising `bus_release`. It then requires the idle value on `bus_out`, `idle` high and `contention` low, with `contention_q` low after the next edge. The same contention pattern with release low is applied next to it, so the bench shows that release is what removes the contention. A second instance in the dual form runs the same vectors against its own expected values.

// File: rtl/gbus_pkg.sv
package gbus_pkg;
  typedef enum logic {
    FORM_AND_ONE = 1'b0,
    FORM_OR_ZERO = 1'b1
  } bus_form_e;
endpackage

// File: rtl/gbus_src_gate.sv
module gbus_src_gate
  import gbus_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter bus_form_e FORM  = FORM_AND_ONE
) (
  input  logic [WIDTH-1:0] word_in,
  input  logic             off,
  output logic [WIDTH-1:0] word_out
);
  generate
    if (FORM == FORM_AND_ONE) begin : g_park_high
      assign word_out = word_in | {WIDTH{off}};
    end else begin : g_park_low
      assign word_out = word_in & {WIDTH{~off}};
    end
  endgenerate
endmodule

// File: rtl/gbus_merge.sv
module gbus_merge
  import gbus_pkg::*;
#(
  parameter int        N_SRC = 12,
  parameter int        WIDTH = 8,
  parameter bus_form_e FORM  = FORM_AND_ONE
) (
  input  logic [N_SRC*WIDTH-1:0] gated,
  output logic [WIDTH-1:0]       merged
);
  function automatic logic [WIDTH-1:0] fold(input logic [N_SRC*WIDTH-1:0] g);
    logic [WIDTH-1:0] acc;
    acc = (FORM == FORM_AND_ONE) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
    for (int i = 0; i < N_SRC; i++) begin
      if (FORM == FORM_AND_ONE) acc = acc & g[i*WIDTH +: WIDTH];
      else                      acc = acc | g[i*WIDTH +: WIDTH];
    end
    return acc;
  endfunction

  assign merged = fold(gated);
endmodule

// File: rtl/gbus_monitor.sv
module gbus_monitor #(
  parameter int N_SRC = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] drive_en,
  output logic             multi,
  output logic             none,
  output logic             multi_q
);
  logic seen_one, seen_two;

  always_comb begin
    seen_one = 1'b0;
    seen_two = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      seen_two = seen_two | (seen_one & drive_en[i]);
      seen_one = seen_one | drive_en[i];
    end
  end

  assign multi = seen_two;
  assign none  = ~seen_one;

  always_ff @(posedge clk) begin
    if (rst) multi_q <= 1'b0;
    else     multi_q <= multi;
  end

  // R5: contention only with at least two drivers
  a_r5_multi_count: assert property (@(posedge clk) disable iff (rst)
    multi |-> ($countones(drive_en) > 1));
  // R6: idle only with no drivers
  a_r6_none_zero: assert property (@(posedge clk) disable iff (rst)
    none |-> ($countones(drive_en) == 0));
  // R8: registered copy tracks the flag
  a_r8_multi_reg: assert property (@(posedge clk) disable iff (rst)
    multi |=> multi_q);
  a_r8_multi_src: assert property (@(posedge clk) disable iff (rst)
    !multi |=> !multi_q);
endmodule

// File: rtl/gbus_top.sv
module gbus_top
  import gbus_pkg::*;
#(
  parameter int        N_SRC = 12,
  parameter int        WIDTH = 8,
  parameter bus_form_e FORM  = FORM_AND_ONE
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC*WIDTH-1:0] src_data,
  input  logic [N_SRC-1:0]       src_dis,
  input  logic                   bus_release,
  output logic [WIDTH-1:0]       bus_out,
  output logic                   contention,
  output logic                   contention_q,
  output logic                   idle
);
  localparam logic [WIDTH-1:0] PARK = (FORM == FORM_AND_ONE) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic [N_SRC-1:0]       eff_off;
  logic [N_SRC-1:0]       drive_en;
  logic [N_SRC*WIDTH-1:0] gated;

  assign eff_off  = src_dis | {N_SRC{bus_release}};
  assign drive_en = ~eff_off;

  generate
    for (genvar k = 0; k < N_SRC; k++) begin : g_src
      gbus_src_gate #(.WIDTH(WIDTH), .FORM(FORM)) u_gate (
        .word_in  (src_data[k*WIDTH +: WIDTH]),
        .off      (eff_off[k]),
        .word_out (gated[k*WIDTH +: WIDTH])
      );
    end
  endgenerate

  gbus_merge #(.N_SRC(N_SRC), .WIDTH(WIDTH), .FORM(FORM)) u_merge (
    .gated  (gated),
    .merged (bus_out)
  );

  gbus_monitor #(.N_SRC(N_SRC)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .drive_en (drive_en),
    .multi    (contention),
    .none     (idle),
    .multi_q  (contention_q)
  );

  // R1/R7: an idle bus shows the park value
  a_r1_idle_park: assert property (@(posedge clk) disable iff (rst)
    idle |-> (bus_out == PARK));
  // R4: release wins over every disable pattern
  a_r4_release_idle: assert property (@(posedge clk) disable iff (rst)
    bus_release |-> (idle && !contention));
  // R5/R6: flags are exclusive
  a_r5_not_both: assert property (@(posedge clk) disable iff (rst)
    !(idle && contention));
endmodule

// File: tb/tb_gbus_top.sv
module tb_gbus_top;
  import gbus_pkg::*;
  localparam int N = 12;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N*W-1:0] data = '0;
  logic [N-1:0] dis = '1;
  logic         rel = 1'b0;
  logic [W-1:0] bus_a, bus_o;
  logic         con_a, con_o, conq_a, conq_o, idl_a, idl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gbus_top #(.N_SRC(N), .WIDTH(W), .FORM(FORM_AND_ONE)) dut (
    .clk(clk), .rst(rst), .src_data(data), .src_dis(dis), .bus_release(rel),
    .bus_out(bus_a), .contention(con_a), .contention_q(conq_a), .idle(idl_a));

  gbus_top #(.N_SRC(N), .WIDTH(W), .FORM(FORM_OR_ZERO)) dut_dual (
    .clk(clk), .rst(rst), .src_data(data), .src_dis(dis), .bus_release(rel),
    .bus_out(bus_o), .contention(con_o), .contention_q(conq_o), .idle(idl_o));

  // {release, disables}
  localparam logic [N:0] VEC [10] = '{
    13'b0_111111111111, 13'b0_111111111110, 13'b0_011111111111,
    13'b0_111110111111, 13'b0_111111111100, 13'b0_010101010101,
    13'b0_000000000000, 13'b1_000000000000, 13'b1_111111110011,
    13'b1_111111111111 };

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int cnt;
    logic [W-1:0] e_and, e_or;
    cnt = 0; e_and = '1; e_or = '0;
    for (int s = 0; s < N; s++) begin
      if (!rel && !dis[s]) begin
        cnt++;
        e_and &= data[s*W +: W];
        e_or  |= data[s*W +: W];
      end
    end
    chk({tag, " R1 R2 R3 R4 bus"}, bus_a, e_and);
    chk({tag, " R7 dual bus"}, bus_o, e_or);
    chk({tag, " R5 contention"}, {7'd0, con_a}, {7'd0, cnt > 1});
    chk({tag, " R6 idle"}, {7'd0, idl_a}, {7'd0, cnt == 0});
    chk({tag, " R5 dual contention"}, {7'd0, con_o}, {7'd0, cnt > 1});
    chk({tag, " R6 dual idle"}, {7'd0, idl_o}, {7'd0, cnt == 0});
  endtask

  task automatic apply(logic [N*W-1:0] d, logic [N-1:0] ds, logic r, string tag);
    logic expq;
    int cnt;
    @(posedge clk); #1;
    data = d; dis = ds; rel = r;
    #1 check_all(tag);
    cnt = 0;
    for (int s = 0; s < N; s++) if (!r && !ds[s]) cnt++;
    expq = (cnt > 1);
    @(posedge clk); #1;
    chk({tag, " R8 contention_q"}, {7'd0, conq_a}, {7'd0, expq});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] d;
    repeat (3) @(posedge clk);
    #1;
    data = {N{8'h3C}}; dis = '0; rel = 1'b0;
    @(posedge clk); #1;
    chk("R8 reset contention_q", {7'd0, conq_a}, 8'd0);
    chk("R8 reset dual contention_q", {7'd0, conq_o}, 8'd0);
    rst = 1'b0;
    dis = '1;

    // table walk
    for (int v = 0; v < 10; v++) begin
      for (int s = 0; s < N; s++) d[s*W +: W] = W'(s * 37 + v * 11) ^ 8'hA5;
      apply(d, VEC[v][N-1:0], VEC[v][N], "table");
    end

    // R2: every single source index with random data
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int s = 0; s < N; s++) begin
        for (int b = 0; b < N; b++) d[b*W +: W] = W'($urandom);
        apply(d, ~(N'(1) << s), 1'b0, "R2 single");
        chk("R2 exact word", bus_a, d[s*W +: W]);
        chk("R2 dual exact word", bus_o, d[s*W +: W]);
      end
    end

    // R3: disabled low words must not leak
    d = '0;
    d[4*W +: W] = 8'hF0;
    d[9*W +: W] = 8'h3F;
    apply(d, ~((N'(1) << 4) | (N'(1) << 9)), 1'b0, "R3 pair");
    chk("R3 and of pair", bus_a, 8'h30);
    chk("R7 or of pair", bus_o, 8'hFF);

    // R4 with contention pending in the same cycle
    apply(d, '0, 1'b1, "R4 release over contention");
    chk("R4 release bus", bus_a, 8'hFF);
    chk("R4 dual release bus", bus_o, 8'h00);
    apply(d, '0, 1'b0, "R5 contention without release");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule